// File: doc/BRIEF.md
# 32-bit Real-Time Counter with Compare

This block is a free-running 32-bit up-counter that advances once per enabled tick of a slow timekeeping clock. The counter returns to zero on the tick after it reaches a programmable period value and raises an overflow flag at that point. A second programmable value is compared with the count at all times. When the count leaves a value equal to the compare value, a compare flag is set. Each flag can raise an interrupt request through its own enable bit. Each flag set also gives a one-cycle event strobe and a wake-up strobe.

Software reaches the block through a byte-wide register port that runs on the counter clock. The count, period and compare values are 32 bits wide, and each is written and read one byte at a time. A write to any period byte, or to the top compare byte, masks flag setting for the next two counter ticks. This keeps a half-updated value from raising a spurious flag. The counter keeps running while flags are masked.

Address map: 0x1 holds the interrupt enables (bit 0 overflow, bit 1 compare). 0x2 holds the flags (bit 0 overflow, bit 1 compare). The count is at 0x4–0x7, the period at 0x8–0xB and the compare value at 0xC–0xF. Within each value the least significant byte is at the lowest address.

Top module: `rtc32_cmp`

## Requirements
- R1: After reset, the count, period, compare value, enables and flags are all zero, and the interrupt, event and wake-up outputs are low.
- R2: On each tick (cnt_en_i high) the count increases by one. When the count equals the period, the tick instead loads zero and sets the overflow flag (flags_o bit 0, register 0x2 bit 0).
- R3: A tick taken while the count equals the compare value sets the compare flag (flags_o bit 1, register 0x2 bit 1). The flag therefore becomes visible together with the next count value. A flag is never set without a tick.
- R4: While the compare value is greater than the period, the compare flag and the compare event are never set.
- R5: A write to any period byte (0x8–0xB) keeps the overflow flag, overflow event and wake-up from being set on the next two ticks.
- R6: A write to the top compare byte (0xF) keeps both flags, both events and wake-up from being set on the next two ticks. Writes to compare bytes 0xC–0xE do not mask anything.
- R7: A byte write to the count (0x4–0x7) replaces that byte, wins over a tick in the same cycle, and masks nothing.
- R8: Writing one to a flag bit in 0x2 clears that flag. Writing zero leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: irq_ovf_o equals overflow flag AND enable bit 0. irq_cmp_o equals compare flag AND enable bit 1.
- R10: ovf_evt_o and cmp_evt_o pulse for one cycle in the cycle after the tick that sets the matching flag. wake_o is high when either event is high.
- R11: Every byte of the count, period, compare value, enables and flags reads back on rdata_o in the same cycle as its address.
- R12: The count keeps advancing while flag setting is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Tick qualifier for the counter clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| flags_o | output | 2 | Flags: bit 0 overflow, bit 1 compare |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| ovf_evt_o | output | 1 | Overflow event strobe |
| cmp_evt_o | output | 1 | Compare event strobe |
| wake_o | output | 1 | Wake-up strobe |

## Verification
Some properties are checked on every cycle:
- the wrap to zero and the plus-one step, including while flags are masked;
- no compare event while the compare value is above the period;
- no event while a masking window is open;
- flags only rising on a tick, and events only after a tick.

The bench's scenarios show the rest:
- the two-tick length of the masking window;
- which writes open it and which do not;
- a set winning over a clear in the same cycle;
- byte-wise readback.

For these scenarios, a reference model in the bench follows random writes and irregular tick patterns.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CTL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CNT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PER = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CMP = 2'd3;
  localparam int CTL_IE_BYTE   = 1;
  localparam int CTL_FLAG_BYTE = 2;
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;
  localparam int N_FLG   = 2;
endpackage

// File: rtl/rtc_byte_reg.sv
module rtc_byte_reg #(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [BW-1:0]   byte_i,
  input  logic [7:0]      wdata_i,
  input  logic            load_i,
  input  logic [8*NB-1:0] load_val_i,
  output logic [8*NB-1:0] q_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[8*b +: 8] <= '0;
      end else if (wr_i) begin
        // software write freezes the whole word for this cycle
        if (byte_i == BW'(b)) q_o[8*b +: 8] <= wdata_i;
      end else if (load_i) begin
        q_o[8*b +: 8] <= load_val_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/rtc_blank.sv
module rtc_blank #(
  parameter int CYC = 2,
  localparam int BW = $clog2(CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic          tick_i,
  output logic [BW-1:0] cnt_o,
  output logic          active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (reload_i)                cnt_o <= BW'(CYC);
    else if (tick_i && cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end
  assign active_o = (cnt_o != '0);
endmodule

// File: rtl/rtc_flag.sv
module rtc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/rtc32_cmp.sv
module rtc32_cmp
  import rtc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BLANK_CYC = 2,
  localparam int NB       = CNT_W / 8,
  localparam int BYTE_W   = $clog2(NB),
  localparam int ADDR_W   = SEL_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_FLG-1:0]  flags_o,
  output logic              irq_ovf_o,
  output logic              irq_cmp_o,
  output logic              ovf_evt_o,
  output logic              cmp_evt_o,
  output logic              wake_o
);
  localparam int BLK_W = $clog2(BLANK_CYC + 1);

  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] byte_idx;
  logic              wr_cnt, wr_per, wr_cmp, wr_cmp_top, wr_ie, wr_flg;
  logic [CNT_W-1:0]  cnt_q, per_q, cmp_q, cnt_nxt;
  logic              ovf_hit, cmp_hit, cmp_ok;
  logic [BLK_W-1:0]  blank_ovf_q, blank_cmp_q;
  logic              blank_ovf, blank_cmp;
  logic [N_FLG-1:0]  flg_set, flg_clr, evt_q, ie_q;

  assign sel        = addr_i[ADDR_W-1 -: SEL_W];
  assign byte_idx   = addr_i[BYTE_W-1:0];
  assign wr_cnt     = wr_en_i && sel == SEL_CNT;
  assign wr_per     = wr_en_i && sel == SEL_PER;
  assign wr_cmp     = wr_en_i && sel == SEL_CMP;
  assign wr_cmp_top = wr_cmp && byte_idx == BYTE_W'(NB - 1);
  assign wr_ie      = wr_en_i && sel == SEL_CTL && byte_idx == BYTE_W'(CTL_IE_BYTE);
  assign wr_flg     = wr_en_i && sel == SEL_CTL && byte_idx == BYTE_W'(CTL_FLAG_BYTE);

  // counter, period and compare byte registers
  assign ovf_hit = cnt_q == per_q;
  assign cnt_nxt = ovf_hit ? '0 : cnt_q + 1'b1;

  rtc_byte_reg #(.NB(NB)) u_cnt (
    .clk_i, .rst_ni, .wr_i(wr_cnt), .byte_i(byte_idx), .wdata_i,
    .load_i(cnt_en_i), .load_val_i(cnt_nxt), .q_o(cnt_q)
  );
  rtc_byte_reg #(.NB(NB)) u_per (
    .clk_i, .rst_ni, .wr_i(wr_per), .byte_i(byte_idx), .wdata_i,
    .load_i(1'b0), .load_val_i('0), .q_o(per_q)
  );
  rtc_byte_reg #(.NB(NB)) u_cmp (
    .clk_i, .rst_ni, .wr_i(wr_cmp), .byte_i(byte_idx), .wdata_i,
    .load_i(1'b0), .load_val_i('0), .q_o(cmp_q)
  );

  // masking windows
  rtc_blank #(.CYC(BLANK_CYC)) u_blank_ovf (
    .clk_i, .rst_ni, .reload_i(wr_per || wr_cmp_top), .tick_i(cnt_en_i),
    .cnt_o(blank_ovf_q), .active_o(blank_ovf)
  );
  rtc_blank #(.CYC(BLANK_CYC)) u_blank_cmp (
    .clk_i, .rst_ni, .reload_i(wr_cmp_top), .tick_i(cnt_en_i),
    .cnt_o(blank_cmp_q), .active_o(blank_cmp)
  );

  assign cmp_ok  = cmp_q <= per_q;
  assign cmp_hit = cnt_q == cmp_q && cmp_ok;

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_OVF] = cnt_en_i && ovf_hit && !blank_ovf;
    flg_set[FLG_CMP] = cnt_en_i && cmp_hit && !blank_cmp;
  end

  for (genvar i = 0; i < N_FLG; i++) begin : g_flg
    assign flg_clr[i] = wr_flg && wdata_i[i];
    rtc_flag u_flag (
      .clk_i, .rst_ni, .set_i(flg_set[i]), .clr_i(flg_clr[i]), .q_o(flags_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      evt_q <= '0;
    end else begin
      evt_q <= flg_set;
      if (wr_ie) ie_q <= wdata_i[N_FLG-1:0];
    end
  end

  assign irq_ovf_o = flags_o[FLG_OVF] & ie_q[FLG_OVF];
  assign irq_cmp_o = flags_o[FLG_CMP] & ie_q[FLG_CMP];
  assign ovf_evt_o = evt_q[FLG_OVF];
  assign cmp_evt_o = evt_q[FLG_CMP];
  assign wake_o    = |evt_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CNT: rdata_o = cnt_q[8*byte_idx +: 8];
      SEL_PER: rdata_o = per_q[8*byte_idx +: 8];
      SEL_CMP: rdata_o = cmp_q[8*byte_idx +: 8];
      default: begin
        if (byte_idx == BYTE_W'(CTL_IE_BYTE))   rdata_o[N_FLG-1:0] = ie_q;
        if (byte_idx == BYTE_W'(CTL_FLAG_BYTE)) rdata_o[N_FLG-1:0] = flags_o;
      end
    endcase
  end
endmodule

// File: rtl/rtc32_cmp_chk.sv
module rtc32_cmp_chk #(
  parameter int CNT_W  = 32,
  parameter int BLK_W  = 2,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  per_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [BLK_W-1:0]  blank_ovf_q,
  input logic [BLK_W-1:0]  blank_cmp_q,
  input logic [1:0]        flags_o,
  input logic              ovf_evt_o,
  input logic              cmp_evt_o
);
  logic cnt_wr;
  assign cnt_wr = wr_en_i && addr_i[ADDR_W-1 -: 2] == 2'd1;

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_wr && cnt_q == per_q) |=> cnt_q == '0);

  p_flag_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> $past(cnt_en_i));

  p_no_cmp_above_per_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_o |-> $past(cmp_q <= per_q));

  p_blank_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ovf_q != '0) |=> !ovf_evt_o);

  p_blank_cmp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_cmp_q != '0) |=> !cmp_evt_o);

  p_evt_after_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_o || cmp_evt_o) |-> $past(cnt_en_i));

  p_count_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_wr && cnt_q != per_q) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

bind rtc32_cmp rtc32_cmp_chk #(
  .CNT_W(CNT_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .cnt_q(cnt_q), .per_q(per_q), .cmp_q(cmp_q),
  .blank_ovf_q(blank_ovf_q), .blank_cmp_q(blank_cmp_q), .flags_o(flags_o),
  .ovf_evt_o(ovf_evt_o), .cmp_evt_o(cmp_evt_o)
);

// File: tb/rtc32_cmp_bench.sv
`timescale 1ns/1ps
module rtc32_cmp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] flags;
  logic       irq_ovf, irq_cmp, ovf_evt, cmp_evt, wake;

  int checks = 0, failures = 0;
  bit done = 0;
  int cmp_evt_seen = 0;

  // reference state
  logic [31:0] m_cnt = 0, m_per = 0, m_cmp = 0;
  logic [1:0]  m_ie = 0, m_flg = 0, m_evt = 0;
  int          m_bo = 0, m_bc = 0;

  always #10 clk = ~clk;

  rtc32_cmp u_rtc32_cmp (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .flags_o(flags),
    .irq_ovf_o(irq_ovf), .irq_cmp_o(irq_cmp), .ovf_evt_o(ovf_evt),
    .cmp_evt_o(cmp_evt), .wake_o(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd(logic [3:0] a);
    case (a[3:2])
      2'd1: return m_cnt[8*a[1:0] +: 8];
      2'd2: return m_per[8*a[1:0] +: 8];
      2'd3: return m_cmp[8*a[1:0] +: 8];
      default: return (a == 4'h1) ? {6'd0, m_ie} : (a == 4'h2) ? {6'd0, m_flg} : 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] put(logic [31:0] v, logic [1:0] b, logic [7:0] d);
    logic [31:0] r = v;
    r[8*b +: 8] = d;
    return r;
  endfunction

  task automatic step(bit tick, bit we, logic [3:0] a, logic [7:0] d);
    bit os, cs;
    logic [1:0] clr;
    @(negedge clk);
    cnt_en = tick; wr_en = we; addr = a; wdata = d;
    #1;
    chk("R11 rdata", {24'd0, rdata}, {24'd0, rd(a)});
    os  = tick && m_cnt == m_per && m_bo == 0;
    cs  = tick && m_cnt == m_cmp && m_cmp <= m_per && m_bc == 0;
    clr = (we && a == 4'h2) ? d[1:0] : 2'b00;
    if (we && a[3:2] == 2'd1) m_cnt = put(m_cnt, a[1:0], d);
    else if (tick) m_cnt = (m_cnt == m_per) ? 32'd0 : m_cnt + 1;
    if (we && a[3:2] == 2'd2) m_per = put(m_per, a[1:0], d);
    if (we && a[3:2] == 2'd3) m_cmp = put(m_cmp, a[1:0], d);
    if (we && a == 4'h1) m_ie = d[1:0];
    if (we && (a[3:2] == 2'd2 || a == 4'hF)) m_bo = 2;
    else if (tick && m_bo != 0) m_bo--;
    if (we && a == 4'hF) m_bc = 2;
    else if (tick && m_bc != 0) m_bc--;
    m_flg[0] = os | (m_flg[0] & ~clr[0]);
    m_flg[1] = cs | (m_flg[1] & ~clr[1]);
    m_evt = {cs, os};
    @(posedge clk);
    #1;
    chk("R2 ovf flag", {31'd0, flags[0]}, {31'd0, m_flg[0]});
    chk("R3 cmp flag", {31'd0, flags[1]}, {31'd0, m_flg[1]});
    chk("R9 irq", {30'd0, irq_cmp, irq_ovf}, {30'd0, m_flg & m_ie});
    chk("R10 events", {29'd0, wake, cmp_evt, ovf_evt}, {29'd0, |m_evt, m_evt});
    if (cmp_evt) cmp_evt_seen++;
  endtask

  task automatic wr32(logic [3:0] base, logic [31:0] v);
    for (int b = 0; b < 4; b++) step(0, 1, base + 4'(b), v[8*b +: 8]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 4'(i), 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #35;
    chk("R1 reset flags", {30'd0, flags}, 32'd0);
    chk("R1 reset outs", {27'd0, irq_ovf, irq_cmp, ovf_evt, cmp_evt, wake}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) step(0, 0, 4'(a), 8'h00);   // R1 readback of zeros

    // R2/R3 basic run
    wr32(4'h8, 32'd9);
    wr32(4'hC, 32'd4);
    step(0, 1, 4'h1, 8'h03);
    idle(30);

    // R4: compare above period
    cmp_evt_seen = 0;
    wr32(4'hC, 32'd20);
    idle(40);
    chk("R4 no cmp event", cmp_evt_seen, 0);

    // R7: count write, no masking
    wr32(4'hC, 32'd3);
    idle(3);
    step(0, 1, 4'h2, 8'h03);
    step(1, 1, 4'h4, 8'h09);           // write wins over tick
    step(0, 0, 4'h4, 8'h00);
    chk("R7 cnt byte write", {24'd0, rdata}, 32'h09);
    step(1, 0, 4'h4, 8'h00);           // tick at cnt==per
    chk("R7 no blank after cnt write", {31'd0, flags[0]}, 32'd1);

    // R5 and R12: period write masks overflow, counter still runs
    step(0, 1, 4'h2, 8'h03);
    step(0, 1, 4'h4, 8'h05);
    step(0, 1, 4'h8, 8'h05);
    step(1, 0, 4'h4, 8'h00);
    chk("R5 ovf masked", {31'd0, flags[0]}, 32'd0);
    step(0, 0, 4'h4, 8'h00);
    chk("R12 count runs while masked", {24'd0, rdata}, 32'd0);

    // R6: top compare byte masks, low byte does not
    step(0, 1, 4'h4, 8'h03);
    step(0, 1, 4'hF, 8'h00);
    step(1, 0, 4'h4, 8'h00);
    chk("R6 cmp masked after top byte", {31'd0, flags[1]}, 32'd0);
    idle(2);
    step(0, 1, 4'h4, 8'h03);
    step(0, 1, 4'hC, 8'h03);
    step(1, 0, 4'h4, 8'h00);
    chk("R6 low byte does not mask", {31'd0, flags[1]}, 32'd1);

    // R8: set wins over clear, then clear works
    step(0, 1, 4'h4, 8'h03);
    step(1, 1, 4'h2, 8'h02);
    chk("R8 set beats clear", {31'd0, flags[1]}, 32'd1);
    step(0, 1, 4'h2, 8'h02);
    chk("R8 clear", {31'd0, flags[1]}, 32'd0);
    step(0, 1, 4'h2, 8'h00);

    // constrained random
    wr32(4'h8, 32'd12);
    wr32(4'hC, 32'd7);
    wr32(4'h4, 32'd0);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      bit tk = ($urandom % 4) != 0;
      if (r < 72)      step(tk, 0, 4'($urandom % 16), 8'h00);
      else if (r < 77) step(tk, 1, 4'h8, 8'(3 + $urandom % 28));
      else if (r < 79) step(tk, 1, 4'(9 + $urandom % 3), 8'h00);
      else if (r < 85) step(tk, 1, 4'hC, 8'($urandom % 36));
      else if (r < 88) step(tk, 1, 4'hF, 8'h00);
      else if (r < 91) step(tk, 1, 4'(4 + $urandom % 4), 8'h00);
      else if (r < 93) step(tk, 1, 4'h4, 8'($urandom % 8));
      else if (r < 98) step(tk, 1, 4'h2, 8'($urandom % 4));
      else             step(tk, 1, 4'h1, 8'($urandom % 4));
    end
    finish_run();
  end
endmodule